// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block hands transmit frames from a descriptor ring in memory to a downstream transmitter. Each descriptor takes 16 bytes at `ring_base + 16*index`. The block reads the control word at byte offset 0 and the buffer address at offsets 8 (low half) and 12 (high half). It never reads the word at offset 4, which holds tag data. In the control word, bit 31 means the hardware owns the descriptor, bit 30 marks the end of the ring, bit 29 marks the first segment, bit 28 marks the last segment, and bits 15:0 give the frame length. The ring base is a 32-bit byte address aligned to 16 bytes; the upper half of the software-visible 64-bit base is always zero, so it is not brought in.

Software starts a pass by writing the poll byte with bit 6 set. From its current index, the engine fetches one descriptor after another. For each descriptor owned by hardware, it offers the buffer address, length and segment flags on a valid/ready output. Once the frame is accepted, it writes the control word back with only the end-of-ring bit kept, pulses the transmit-done status, and moves on. After a descriptor with the end-of-ring bit, the next index is 0; otherwise the index increments. When it meets a descriptor owned by the host, it pulses descriptor-unavailable and goes idle at that index.

The memory port is a valid/ready request channel. Read data returns on `mem_rvalid` in some later cycle and cannot be back-pressured. Only one read is ever outstanding. On both channels, a request holds its payload unchanged until it is accepted.

Top module: `txr_engine`

## Requirements
- R1: After reset, `mem_valid`, `tx_valid`, `sts_tok` and `sts_tdu` are 0 and the ring index is 0, so the first fetch after a poll reads byte address `ring_base`.
- R2: A poll write starts a pass only when `poll_wdata` bit 6 is 1; a write with bit 6 clear produces no memory request.
- R3: For each descriptor, the control word (offset 0) is read first; offsets 8 and 12 are read only if control bit 31 is 1; offset 4 is never read.
- R4: For an owned descriptor, `tx_buf_addr` = {word at offset 12, word at offset 8}, `tx_len` = control[15:0], `tx_first` = control[29], `tx_last` = control[28], and these hold steady with `tx_valid` until `tx_ready`.
- R5: After the frame is accepted, the engine writes to the descriptor's control address the value (control[30] << 30); every other bit of that value is 0.
- R6: `sts_tok` pulses for one cycle, in the cycle after the write-back is accepted, once per completed descriptor.
- R7: After a completed descriptor, the index becomes 0 if its control bit 30 was 1, and index+1 otherwise.
- R8: A fetched control word with bit 31 clear gives one `sts_tdu` pulse, no write, no output frame, and leaves the index at that descriptor.
- R9: A poll that arrives while a pass is running is remembered, and one further pass starts from the stop index once the engine is idle.
- R10: A memory request that is not accepted keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0, 16-byte aligned |
| poll_we | input | 1 | Poll byte write strobe |
| poll_wdata | input | 8 | Poll byte; bit 6 requests a pass |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame descriptor offered |
| tx_ready | input | 1 | Downstream accepts the frame |
| tx_buf_addr | output | 64 | Buffer address |
| tx_len | output | 16 | Frame length in bytes |
| tx_first | output | 1 | First segment flag |
| tx_last | output | 1 | Last segment flag |
| sts_tok | output | 1 | One-cycle transmit-done pulse |
| sts_tdu | output | 1 | One-cycle descriptor-unavailable pulse |

## Verification
The case that is hardest to reach from the ports is a poll that lands while a pass is still running. That poll must cause a second fetch of the descriptor where the engine stopped. The stimulus hands exactly three descriptors to hardware, polls, and polls again a few cycles later, while the first fetches are still stalled by random memory back-pressure. The bench then expects two unavailable pulses and two reads of the same stop address. Randomly placed ownership and end-of-ring marks, together with a ring shadow in the bench, drive wrap-around and the stop at a descriptor cleared earlier in the same pass.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_BIT   = 31;
  localparam int EOR_BIT   = 30;
  localparam int FS_BIT    = 29;
  localparam int LS_BIT    = 28;
  localparam int LEN_W     = 16;
  localparam int POLL_BIT  = 6;
  localparam int DESC_SHIFT = 4;
  localparam int OFF_CTL   = 0;
  localparam int OFF_LO    = 8;
  localparam int OFF_HI    = 12;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RQ_CTL, ST_WT_CTL, ST_RQ_LO, ST_WT_LO,
    ST_RQ_HI, ST_WT_HI, ST_SEND, ST_WB
  } txr_state_e;

  typedef struct packed {
    logic             eor;
    logic             first;
    logic             last;
    logic [LEN_W-1:0] len;
  } txr_ctl_t;
endpackage

// File: rtl/txr_kick.sv
module txr_kick
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_we,
  input  logic [7:0] poll_wdata,
  input  logic       idle,
  output logic       go
);
  logic kick;
  logic pend_q;
  logic unused_poll_bits;

  assign kick = poll_we & poll_wdata[POLL_BIT];
  assign unused_poll_bits = ^{poll_wdata[7], poll_wdata[5:0]};
  assign go = idle & (kick | pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (go) begin
      pend_q <= 1'b0;
    end else if (kick) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/txr_index.sv
module txr_index
  import txr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] desc_addr
);
  localparam int OFFW = IDXW + DESC_SHIFT;

  logic [IDXW-1:0] idx_q;
  logic [OFFW-1:0] off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= wrap ? '0 : idx_q + 1'b1;
    end
  end

  assign off       = {idx_q, {DESC_SHIFT{1'b0}}};
  assign desc_addr = ring_base + AW'(off);
endmodule

// File: rtl/txr_desc_hold.sv
module txr_desc_hold
  import txr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_ctl,
  input  logic [1:0]  ld_buf,
  input  logic [31:0] din,
  output txr_ctl_t    ctl,
  output logic [63:0] buf_addr
);
  logic [31:0] buf_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ld_ctl) begin
      ctl.eor   <= din[EOR_BIT];
      ctl.first <= din[FS_BIT];
      ctl.last  <= din[LS_BIT];
      ctl.len   <= din[LEN_W-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q[g] <= '0;
      end else if (ld_buf[g]) begin
        buf_q[g] <= din;
      end
    end
  end

  assign buf_addr = {buf_q[1], buf_q[0]};
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] desc_addr,
  input  logic          eor_q,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic          rd_own,
  output logic          ld_ctl,
  output logic [1:0]    ld_buf,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          adv,
  output logic          idle,
  output logic          sts_tok,
  output logic          sts_tdu
);
  txr_state_e st_q, st_d;
  logic [AW-1:0] off;
  logic          miss;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (go) st_d = ST_RQ_CTL;
      ST_RQ_CTL: if (mem_ready) st_d = ST_WT_CTL;
      ST_WT_CTL: if (mem_rvalid) st_d = rd_own ? ST_RQ_LO : ST_IDLE;
      ST_RQ_LO:  if (mem_ready) st_d = ST_WT_LO;
      ST_WT_LO:  if (mem_rvalid) st_d = ST_RQ_HI;
      ST_RQ_HI:  if (mem_ready) st_d = ST_WT_HI;
      ST_WT_HI:  if (mem_rvalid) st_d = ST_SEND;
      ST_SEND:   if (tx_ready) st_d = ST_WB;
      ST_WB:     if (mem_ready) st_d = ST_RQ_CTL;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sts_tok <= 1'b0;
      sts_tdu <= 1'b0;
    end else begin
      st_q    <= st_d;
      sts_tok <= adv;
      sts_tdu <= miss;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RQ_LO: off = AW'(OFF_LO);
      ST_RQ_HI: off = AW'(OFF_HI);
      default:  off = AW'(OFF_CTL);
    endcase
  end

  assign mem_valid = (st_q == ST_RQ_CTL) || (st_q == ST_RQ_LO) ||
                     (st_q == ST_RQ_HI)  || (st_q == ST_WB);
  assign mem_we    = (st_q == ST_WB);
  assign mem_addr  = desc_addr + off;
  assign mem_wdata = {1'b0, eor_q, 30'd0};

  assign ld_ctl    = (st_q == ST_WT_CTL) && mem_rvalid;
  assign ld_buf[0] = (st_q == ST_WT_LO) && mem_rvalid;
  assign ld_buf[1] = (st_q == ST_WT_HI) && mem_rvalid;
  assign miss      = ld_ctl && !rd_own;

  assign tx_valid  = (st_q == ST_SEND);
  assign adv       = (st_q == ST_WB) && mem_ready;
  assign idle      = (st_q == ST_IDLE);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          poll_we,
  input  logic [7:0]    poll_wdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [63:0]   tx_buf_addr,
  output logic [15:0]   tx_len,
  output logic          tx_first,
  output logic          tx_last,
  output logic          sts_tok,
  output logic          sts_tdu
);
  logic          go, idle, adv, ld_ctl;
  logic [1:0]    ld_buf;
  logic [AW-1:0] desc_addr;
  txr_ctl_t      ctl;

  txr_kick u_kick (
    .clk(clk), .rst_n(rst_n), .poll_we(poll_we), .poll_wdata(poll_wdata),
    .idle(idle), .go(go)
  );

  txr_index #(.AW(AW), .IDXW(IDXW)) u_index (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .adv(adv),
    .wrap(ctl.eor), .desc_addr(desc_addr)
  );

  txr_desc_hold u_hold (
    .clk(clk), .rst_n(rst_n), .ld_ctl(ld_ctl), .ld_buf(ld_buf),
    .din(mem_rdata), .ctl(ctl), .buf_addr(tx_buf_addr)
  );

  txr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .desc_addr(desc_addr), .eor_q(ctl.eor),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .rd_own(mem_rdata[OWN_BIT]), .ld_ctl(ld_ctl), .ld_buf(ld_buf),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .adv(adv), .idle(idle),
    .sts_tok(sts_tok), .sts_tdu(sts_tdu)
  );

  assign tx_len   = ctl.len;
  assign tx_first = ctl.first;
  assign tx_last  = ctl.last;
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [63:0]   tx_buf_addr,
  input logic [15:0]   tx_len,
  input logic          sts_tok,
  input logic          sts_tdu
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_buf_addr) && $stable(tx_len));

  p_wb_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> !mem_wdata[31] && (mem_wdata[29:0] == 30'd0));

  p_tok_after_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_tok |-> $past(mem_valid && mem_ready && mem_we));

  p_tdu_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_tdu |-> !mem_valid && !tx_valid && !sts_tok);

  p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_valid));
endmodule

bind txr_engine txr_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/txr_engine_bench.sv
module txr_engine_bench;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h200;
  localparam int W0 = 32'h200 >> 2;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          poll_we = 0;
  logic [7:0]    poll_wdata = 0;
  logic          mem_valid, mem_we, mem_ready = 0, mem_rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata = 0;
  logic          tx_valid, tx_ready = 0, tx_first, tx_last, sts_tok, sts_tdu;
  logic [63:0]   tx_buf_addr;
  logic [15:0]   tx_len;

  txr_engine #(.AW(AW), .IDXW(10)) u_txr_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .poll_we(poll_we),
    .poll_wdata(poll_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
    .tx_first(tx_first), .tx_last(tx_last), .sts_tok(sts_tok), .sts_tdu(sts_tdu)
  );

  // memory and downstream model
  logic [31:0] mem [256];
  logic        h_we = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_data = 0;

  always @(posedge clk) begin
    mem_ready  <= ($urandom % 4) != 0;
    tx_ready   <= ($urandom % 3) != 0;
    mem_rvalid <= mem_valid && mem_ready && !mem_we;
    mem_rdata  <= mem[mem_addr[9:2]];
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (h_we) mem[h_addr] <= h_data;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expectation
  logic [63:0] exp_addr [40];
  logic [15:0] exp_len [40];
  logic        exp_fs [40], exp_ls [40];
  int          exp_slot [40];
  int          n_exp, exp_stop, cur_idx;
  logic [31:0] orig_ctl [16];
  bit          visited [16];

  task automatic compute_expect(input int start);
    logic [31:0] sh [16];
    int idx;
    for (int s = 0; s < 16; s++) begin
      sh[s] = mem[W0 + 4*s]; orig_ctl[s] = sh[s]; visited[s] = 0;
    end
    n_exp = 0; idx = start;
    for (int step = 0; step < 40; step++) begin
      if (!sh[idx][31]) break;
      exp_addr[n_exp] = {mem[W0 + 4*idx + 3], mem[W0 + 4*idx + 2]};
      exp_len[n_exp]  = sh[idx][15:0];
      exp_fs[n_exp]   = sh[idx][29];
      exp_ls[n_exp]   = sh[idx][28];
      exp_slot[n_exp] = idx;
      n_exp++;
      visited[idx] = 1;
      sh[idx][31] = 1'b0;
      idx = sh[idx][30] ? 0 : idx + 1;
    end
    exp_stop = idx;
  endtask

  // monitor
  int frames_seen, tok_seen, tdu_seen, wb_seen, acc_seen, bad_reads;
  logic [31:0] last_ctl_addr;
  bit          prev_mstall, prev_tstall;
  logic [31:0] prev_maddr;
  logic [63:0] prev_taddr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_mstall)
        chk(mem_valid && mem_addr == prev_maddr, "R10 request held", mem_addr, prev_maddr);
      if (prev_tstall)
        chk(tx_valid && tx_buf_addr == prev_taddr, "R4 frame held", tx_buf_addr, prev_taddr);
      prev_mstall = mem_valid && !mem_ready;
      prev_maddr  = mem_addr;
      prev_tstall = tx_valid && !tx_ready;
      prev_taddr  = tx_buf_addr;
      if (mem_valid && mem_ready) begin
        acc_seen++;
        if (mem_we) begin
          if (wb_seen < n_exp) begin
            chk(mem_addr == BASE + 16*exp_slot[wb_seen], "R5 wb addr", mem_addr, BASE + 16*exp_slot[wb_seen]);
            chk(mem_wdata == (orig_ctl[exp_slot[wb_seen]] & 32'h4000_0000), "R5 wb data",
                mem_wdata, orig_ctl[exp_slot[wb_seen]] & 32'h4000_0000);
          end else chk(0, "R5 extra write", mem_addr, 0);
          wb_seen++;
        end else begin
          if (mem_addr[3:0] == 4'h0) last_ctl_addr = mem_addr;
          else if (mem_addr[3:0] != 4'h8 && mem_addr[3:0] != 4'hC) bad_reads++;
        end
      end
      if (tx_valid && tx_ready) begin
        if (frames_seen < n_exp) begin
          chk(tx_buf_addr == exp_addr[frames_seen], "R4 buf addr", tx_buf_addr, exp_addr[frames_seen]);
          chk({tx_len, tx_first, tx_last} == {exp_len[frames_seen], exp_fs[frames_seen], exp_ls[frames_seen]},
              "R4 len/flags", {tx_len, tx_first, tx_last},
              {exp_len[frames_seen], exp_fs[frames_seen], exp_ls[frames_seen]});
        end else chk(0, "R4 extra frame", tx_buf_addr, 0);
        frames_seen++;
      end
      if (sts_tok) tok_seen++;
      if (sts_tdu) tdu_seen++;
    end
  end

  task automatic clear_counts();
    frames_seen = 0; tok_seen = 0; tdu_seen = 0; wb_seen = 0;
    acc_seen = 0; bad_reads = 0; last_ctl_addr = 32'hFFFF_FFFF;
  endtask

  task automatic hwrite(input int w, input logic [31:0] d);
    @(negedge clk); h_we = 1; h_addr = 8'(w); h_data = d;
  endtask

  task automatic fill(input logic [15:0] own_m, input logic [15:0] eor_m);
    for (int s = 0; s < 16; s++) begin
      logic [31:0] c;
      c = {own_m[s], eor_m[s], 1'($urandom), 1'($urandom), 12'd0, 16'($urandom)};
      hwrite(W0 + 4*s, c);
      hwrite(W0 + 4*s + 1, $urandom);
      hwrite(W0 + 4*s + 2, $urandom);
      hwrite(W0 + 4*s + 3, $urandom);
    end
    @(negedge clk); h_we = 0;
    @(negedge clk);
  endtask

  task automatic do_poll(input logic [7:0] d);
    @(negedge clk); poll_we = 1; poll_wdata = d;
    @(negedge clk); poll_we = 0; poll_wdata = 0;
  endtask

  task automatic run_pass(input int polls, input string tag);
    compute_expect(cur_idx);
    clear_counts();
    do_poll(8'h40);
    if (polls == 2) begin
      repeat (2) @(negedge clk);
      do_poll(8'hC1);
    end
    for (int c = 0; c < 4000 && tdu_seen < polls; c++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(frames_seen == n_exp, {tag, " R4 frame count"}, frames_seen, n_exp);
    chk(tok_seen == n_exp, {tag, " R6 tok count"}, tok_seen, n_exp);
    chk(wb_seen == n_exp, {tag, " R5 wb count"}, wb_seen, n_exp);
    chk(tdu_seen == polls, {tag, " R8/R9 tdu count"}, tdu_seen, polls);
    chk(bad_reads == 0, {tag, " R3 read offsets"}, bad_reads, 0);
    chk(last_ctl_addr == BASE + 16*exp_stop, {tag, " R7 stop index"}, last_ctl_addr, BASE + 16*exp_stop);
    for (int s = 0; s < 16; s++) begin
      logic [31:0] e;
      e = visited[s] ? (orig_ctl[s] & 32'h4000_0000) : orig_ctl[s];
      chk(mem[W0 + 4*s] == e, {tag, " R5 ctl after"}, mem[W0 + 4*s], e);
    end
    cur_idx = exp_stop;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    n_exp = 0; cur_idx = 0;
    clear_counts();
    for (int w = 0; w < 256; w++) hwrite(w, 32'd0);
    @(negedge clk); h_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({mem_valid, tx_valid, sts_tok, sts_tdu} == 4'b0, "R1 reset outputs", {mem_valid, tx_valid, sts_tok, sts_tdu}, 0);

    // poll without bit 6
    fill(16'h000F, 16'h8008);
    clear_counts();
    do_poll(8'hBF);
    repeat (30) @(negedge clk);
    chk(acc_seen == 0, "R2 poll bit clear ignored", acc_seen, 0);
    chk(tdu_seen == 0, "R2 no tdu", tdu_seen, 0);

    // wrap at end-of-ring, stop at cleared descriptor
    run_pass(1, "wrap");
    // nothing owned
    fill(16'h0000, 16'h8000);
    run_pass(1, "empty");
    chk(frames_seen == 0, "R8 no frame", frames_seen, 0);
    // three owned, second poll while busy
    fill(16'h0007, 16'h8000);
    run_pass(2, "pend");

    // reset returns index to base
    chk(cur_idx != 0, "R1 precondition index moved", cur_idx, 1);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk({mem_valid, tx_valid, sts_tok, sts_tdu} == 4'b0, "R1 outputs after reset", {mem_valid, tx_valid, sts_tok, sts_tdu}, 0);
    cur_idx = 0;
    fill(16'h0001, 16'h8000);
    run_pass(1, "R1 after reset");

    // random rings
    for (int it = 0; it < 25; it++) begin
      fill(16'($urandom) & 16'($urandom) | 16'($urandom), 16'($urandom) & 16'($urandom) | 16'h8000);
      run_pass(1, "random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule